// File: doc/BRIEF.md
# USB Device Event Flag Register

This block collects single-cycle event pulses from a USB device controller and holds each one as a sticky flag in a 32-bit status word. Software reads the word through a plain read port and acknowledges an event by writing a zero into that flag's bit. Writing a one into a bit leaves that bit unchanged, so one write can acknowledge some flags and keep the others.

Two flags come from logic inside the block and not from a single pulse. The error flag is the OR of four error pulses: response timeout, CRC error, bit-stuffing error and framing violation. The threshold flag comes from a counter that adds up the isochronous bytes moved. It fires when the running total reaches 512. When the wakeup event arrives, the block also sends a one-cycle pulse that clears the low-power mode control bit elsewhere. It also drives a wakeup line that stays high while the wakeup flag is set.

Top module: `usb_evt_flags`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdData` reads zero and both `lowPowerClr` and `wakeLine` are low.
- R2: Each direct event pulse sets its flag, and the flag shows on `rdData` one clock after the pulse. The bit positions are: L1 request bit 7, missed SOF bit 8, SOF bit 9, bus reset/connect bit 10, suspend bit 11, wakeup bit 12, packet-memory overrun bit 14.
- R3: A write (`wrEn` high) clears every flag whose bit in `wrData` is 0 and leaves every flag whose bit is 1 unchanged. The change shows one clock after the write.
- R4: When an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R5: Bit 13 sets one clock after any of `errTimeout`, `errCrc`, `errStuff` or `errFrame` is high.
- R6: In each cycle with `isoValid` high, `isoBytes` is added to a running count. When the sum reaches 512 or more, bit 16 sets one clock later and the count restarts at zero. Any bytes beyond 512 are dropped.
- R7: `evtBusReset` zeroes the byte count. Bytes presented in the same cycle are discarded.
- R8: One clock after `evtWake`, `lowPowerClr` is high for exactly one cycle. `wakeLine` is high for exactly as long as bit 12 is set.
- R9: Bits 0–6, 15 and 17–31 always read zero, and writes to them have no effect.
- R10: A set flag stays set until a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the flag word |
| wrData | input | 32 | Write data; a 0 bit clears that flag |
| rdData | output | 32 | Current flag word |
| evtL1Req | input | 1 | L1 entry request accepted |
| evtSofMissed | input | 1 | Expected SOF did not arrive |
| evtSof | input | 1 | SOF received |
| evtBusReset | input | 1 | Bus reset or connect change |
| evtSuspend | input | 1 | Suspend condition detected |
| evtWake | input | 1 | Bus activity during suspend |
| evtMemOverrun | input | 1 | Packet memory over/underrun |
| errTimeout | input | 1 | No host answer in time |
| errCrc | input | 1 | CRC mismatch |
| errStuff | input | 1 | Bit-stuffing violation |
| errFrame | input | 1 | Framing violation |
| isoValid | input | 1 | Isochronous bytes moved this cycle |
| isoBytes | input | 3 | Number of bytes moved this cycle |
| lowPowerClr | output | 1 | One-cycle pulse to clear low-power mode |
| wakeLine | output | 1 | Wakeup indication, high while bit 12 is set |

## Verification
Every flag change, whether from an event, a merged error, a threshold crossing or a write, is due exactly one clock after the inputs that cause it. The `lowPowerClr` pulse follows the same one-clock rule. The bench drives inputs at the falling edge and advances a behavioural model at the following rising edge. It then compares `rdData`, `lowPowerClr` and `wakeLine` at the next falling edge, so each result is checked in the cycle it is due. The threshold is exercised with several byte sizes per cycle, so the exact cycle of the crossing and the dropping of excess bytes are both checked.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_DIRECT = 7;

  localparam int BIT_L1    = 7;
  localparam int BIT_SOFM  = 8;
  localparam int BIT_SOF   = 9;
  localparam int BIT_BRST  = 10;
  localparam int BIT_SUSP  = 11;
  localparam int BIT_WAKE  = 12;
  localparam int BIT_ERR   = 13;
  localparam int BIT_OVR   = 14;
  localparam int BIT_THR   = 16;

  // Position of each direct event, index order matches the event vector.
  localparam int DIRECT_POS [NUM_DIRECT] =
    '{BIT_L1, BIT_SOFM, BIT_SOF, BIT_BRST, BIT_SUSP, BIT_WAKE, BIT_OVR};

  function automatic logic [REG_W-1:0] liveMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_DIRECT; i++) m[DIRECT_POS[i]] = 1'b1;
    m[BIT_ERR] = 1'b1;
    m[BIT_THR] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] LIVE_MASK = liveMask();

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_ADD  = 2'd1,
    CNT_ZERO = 2'd2
  } cntOpT;

  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    cntOpT            cntOp;
    logic             lpPulse;
  } strobeT;
endpackage

// File: rtl/usb_evt_ctrl.sv
module usb_evt_ctrl
  import usb_evt_pkg::*;
(
  input  logic                   wrEn,
  input  logic [REG_W-1:0]       wrData,
  input  logic [NUM_DIRECT-1:0]  directEvt,
  input  logic [3:0]             errEvt,
  input  logic                   busReset,
  input  logic                   isoValid,
  input  logic                   thrHit,
  output strobeT                 strb
);
  logic [REG_W-1:0] directMask;

  // Scatter the direct events onto their flag positions.
  always_comb begin
    directMask = '0;
    for (int i = 0; i < NUM_DIRECT; i++) begin
      directMask[DIRECT_POS[i]] = directEvt[i];
    end
  end

  always_comb begin
    strb.setMask          = directMask;
    strb.setMask[BIT_ERR] = |errEvt;
    strb.setMask[BIT_THR] = thrHit & ~busReset;
    strb.clrMask          = wrEn ? (~wrData & LIVE_MASK) : '0;
    strb.lpPulse          = directEvt[5];
    if (busReset)      strb.cntOp = CNT_ZERO;
    else if (thrHit)   strb.cntOp = CNT_ZERO;
    else if (isoValid) strb.cntOp = CNT_ADD;
    else               strb.cntOp = CNT_HOLD;
  end
endmodule

// File: rtl/usb_evt_dp.sv
module usb_evt_dp
  import usb_evt_pkg::*;
#(
  parameter int THRESH  = 512,
  parameter int BYTES_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic               isoValid,
  input  logic [BYTES_W-1:0] isoBytes,
  output logic               thrHit,
  output logic [REG_W-1:0]   flags,
  output logic               lpOut
);
  localparam int CNT_W = $clog2(THRESH) + 1;

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W:0]   byteSum;

  assign byteSum = {1'b0, byteCnt} + {{(CNT_W+1-BYTES_W){1'b0}}, isoBytes};
  assign thrHit  = isoValid && (byteSum >= (CNT_W+1)'(THRESH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      lpOut <= 1'b0;
    end else begin
      flags <= ((flags & ~strb.clrMask) | strb.setMask) & LIVE_MASK;
      lpOut <= strb.lpPulse;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else begin
      case (strb.cntOp)
        CNT_ADD:  byteCnt <= byteSum[CNT_W-1:0];
        CNT_ZERO: byteCnt <= '0;
        default:  byteCnt <= byteCnt;
      endcase
    end
  end
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_evt_pkg::*;
#(
  parameter int THRESH  = 512,
  parameter int BYTES_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic               evtL1Req,
  input  logic               evtSofMissed,
  input  logic               evtSof,
  input  logic               evtBusReset,
  input  logic               evtSuspend,
  input  logic               evtWake,
  input  logic               evtMemOverrun,
  input  logic               errTimeout,
  input  logic               errCrc,
  input  logic               errStuff,
  input  logic               errFrame,
  input  logic               isoValid,
  input  logic [BYTES_W-1:0] isoBytes,
  output logic               lowPowerClr,
  output logic               wakeLine
);
  strobeT                strb;
  logic                  thrHit;
  logic [NUM_DIRECT-1:0] directEvt;
  logic [REG_W-1:0]      flags;

  assign directEvt = {evtMemOverrun, evtWake, evtSuspend, evtBusReset,
                      evtSof, evtSofMissed, evtL1Req};

  usb_evt_ctrl ctrl_i (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .directEvt (directEvt),
    .errEvt    ({errFrame, errStuff, errCrc, errTimeout}),
    .busReset  (evtBusReset),
    .isoValid  (isoValid),
    .thrHit    (thrHit),
    .strb      (strb)
  );

  usb_evt_dp #(.THRESH(THRESH), .BYTES_W(BYTES_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .isoValid (isoValid),
    .isoBytes (isoBytes),
    .thrHit   (thrHit),
    .flags    (flags),
    .lpOut    (lowPowerClr)
  );

  assign rdData   = flags;
  assign wakeLine = flags[BIT_WAKE];
endmodule

// File: rtl/usb_evt_flags_chk.sv
module usb_evt_flags_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        evtSof,
  input logic        evtWake,
  input logic        errTimeout,
  input logic        errCrc,
  input logic        errStuff,
  input logic        errFrame,
  input logic        lowPowerClr,
  input logic        wakeLine
);
  a_r2_sof_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtSof |=> rdData[9]);

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (evtSof && wrEn && !wrData[9]) |=> rdData[9]);

  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[9] && !evtSof) |=> !rdData[9]);

  a_r5_err_merge: assert property (@(posedge clk) disable iff (!rstN)
    (errTimeout || errCrc || errStuff || errFrame) |=> rdData[13]);

  a_r8_lp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evtWake |=> lowPowerClr);

  a_r8_lp_single: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerClr && !evtWake) |=> !lowPowerClr);

  a_r8_wake_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeLine) |-> $past(evtWake));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[6:0] == 7'd0) && !rdData[15] && (rdData[31:17] == 15'd0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[9] && !wrEn) |=> rdData[9]);
endmodule

bind usb_evt_flags usb_evt_flags_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .evtSof      (evtSof),
  .evtWake     (evtWake),
  .errTimeout  (errTimeout),
  .errCrc      (errCrc),
  .errStuff    (errStuff),
  .errFrame    (errFrame),
  .lowPowerClr (lowPowerClr),
  .wakeLine    (wakeLine)
);

// File: tb/usb_evt_flags_tb_top.sv
module usb_evt_flags_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic evtL1Req = 0, evtSofMissed = 0, evtSof = 0, evtBusReset = 0;
  logic evtSuspend = 0, evtWake = 0, evtMemOverrun = 0;
  logic errTimeout = 0, errCrc = 0, errStuff = 0, errFrame = 0;
  logic isoValid = 0;
  logic [2:0] isoBytes = '0;
  logic lowPowerClr, wakeLine;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  logic [31:0] expFlags = '0;
  logic expLp = 1'b0;
  int expCnt = 0;

  always #5 clk = ~clk;

  usb_evt_flags dut_i (.*);

  // Flags the design owns, at their fixed positions
  localparam logic [31:0] USED = 32'h0001_7F80;

  task automatic modelStep();
    logic [31:0] setV, clrV;
    int s;
    if (!rstN) begin
      expFlags = '0; expLp = 0; expCnt = 0;
      return;
    end
    setV = '0;
    setV[7] = evtL1Req; setV[8] = evtSofMissed; setV[9] = evtSof;
    setV[10] = evtBusReset; setV[11] = evtSuspend; setV[12] = evtWake;
    setV[14] = evtMemOverrun;
    setV[13] = errTimeout | errCrc | errStuff | errFrame;
    if (evtBusReset) expCnt = 0;
    else if (isoValid) begin
      s = expCnt + int'(isoBytes);
      if (s >= 512) begin setV[16] = 1'b1; expCnt = 0; end
      else expCnt = s;
    end
    clrV = wrEn ? (~wrData & USED) : '0;
    expFlags = (expFlags & ~clrV) | setV;
    expLp = evtWake;
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("rdData", rdData, expFlags);
    check("lowPowerClr", {31'd0, lowPowerClr}, {31'd0, expLp});
    check("wakeLine", {31'd0, wakeLine}, {31'd0, expFlags[12]});
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic quiet();
    wrEn = 0; wrData = '0;
    evtL1Req = 0; evtSofMissed = 0; evtSof = 0; evtBusReset = 0;
    evtSuspend = 0; evtWake = 0; evtMemOverrun = 0;
    errTimeout = 0; errCrc = 0; errStuff = 0; errFrame = 0;
    isoValid = 0; isoBytes = '0;
  endtask

  task automatic writeWord(logic [31:0] d);
    wrEn = 1; wrData = d;
    tick();
    quiet();
  endtask

  task automatic isoRun(int bytesPer, int n);
    for (int i = 0; i < n; i++) begin
      isoValid = 1; isoBytes = 3'(bytesPer);
      tick();
    end
    quiet();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    quiet();
    // R1: reset state
    curReq = "R1";
    repeat (3) tick();
    @(negedge clk); rstN = 1;
    tick();

    // R2: each direct event alone
    curReq = "R2";
    evtL1Req = 1; tick(); quiet();
    evtSofMissed = 1; tick(); quiet();
    evtSof = 1; tick(); quiet();
    evtBusReset = 1; tick(); quiet();
    evtSuspend = 1; tick(); quiet();
    evtMemOverrun = 1; tick(); quiet();

    // R10: flags hold without writes
    curReq = "R10";
    repeat (5) tick();

    // R3: write zeros clear, ones keep
    curReq = "R3";
    writeWord(32'hFFFF_FDFF);   // clear SOF only
    writeWord(32'hFFFF_FFFF);   // nothing changes
    writeWord(32'h0000_0000);   // clear all
    tick();

    // R4: set and clear in the same cycle
    curReq = "R4";
    evtSof = 1; evtSuspend = 1; wrEn = 1; wrData = 32'h0; tick(); quiet();
    writeWord(32'h0);

    // R5: each error source merges into bit 13
    curReq = "R5";
    errTimeout = 1; tick(); quiet(); writeWord(32'h0);
    errCrc = 1; tick(); quiet(); writeWord(32'h0);
    errStuff = 1; tick(); quiet(); writeWord(32'h0);
    errFrame = 1; tick(); quiet(); writeWord(32'h0);

    // R8: wakeup pulse and line
    curReq = "R8";
    evtWake = 1; tick(); quiet();
    repeat (3) tick();
    writeWord(32'hFFFF_EFFF);
    tick();

    // R6: threshold with several byte sizes
    curReq = "R6";
    isoRun(4, 130);
    writeWord(32'h0);
    isoRun(7, 80);
    isoRun(3, 120);
    isoValid = 1; isoBytes = 3'd0; tick(); quiet();
    writeWord(32'h0);

    // R7: bus reset zeroes the count
    curReq = "R7";
    isoRun(4, 100);
    evtBusReset = 1; isoValid = 1; isoBytes = 3'd4; tick(); quiet();
    isoRun(4, 100);
    isoRun(4, 40);
    writeWord(32'h0);

    // R9: reserved bits ignore writes
    curReq = "R9";
    writeWord(32'hFFFE_807F);
    evtSof = 1; wrEn = 1; wrData = 32'hFFFF_FFFF; tick(); quiet();
    writeWord(32'h0);
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule